// File: doc/BRIEF.md
# GPIO Port Register Bank

This block controls a 32-pin general-purpose I/O port from a simple register bus that has an address, write data, a write strobe and combinational read data. Each pin has four pieces of state: a direction bit, a pull-up disable bit, a 2-bit function select and an output latch. The output latch has a whole-word data write. It also has three atomic ports that set, clear or toggle single bits, so that no read-modify-write sequence can overwrite a pin that another agent changed in the meantime. Software preloads the latch while a pin is still an input, and the pin then drives that value as soon as it becomes an output.

Each pin has a 4:1 mux in front of the pad. Function 0 connects the pad to the GPIO latch and direction bit. Functions 1 to 3 give the pad to one of three peripheral output/enable pairs. Reads of the data register return the input level of every pin after two synchronizing flops. The direction, pull-up and function registers accept writes only while a protection flag is open. A strobe register opens the flag and another closes it.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, direction, pull-up control, function select and output latch are all 0, the protection flag is closed, `pad_oe` is 0 and `pad_pu_en` is all ones.
- R2: Function field of pin i is bits [2i+1:2i] across two registers: address 6 holds pins 0-15 and address 7 holds pins 16-31. Code 00 selects GPIO. Codes 01, 10 and 11 select peripheral k = 1, 2, 3. In that case `pad_out[i]` = `per_out[(k-1)*32+i]` and `pad_oe[i]` = `per_oe[(k-1)*32+i]`, and the direction and latch bits have no effect.
- R3: In GPIO mode the direction register (address 4) makes the pin an output with bit 1 and an input with bit 0; `pad_oe[i]` follows it.
- R4: A write to address 1 sets every latch bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R5: A write to address 2 clears every latch bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R6: A write to address 3 inverts every latch bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R7: Pull-up control (address 5) bit 0 enables the pull-up and bit 1 disables it: `pad_pu_en` = inverse of that register.
- R8: In GPIO mode `pad_out` shows the latch whatever the direction, so a value loaded while the pin is an input is driven as soon as its direction bit becomes 1.
- R9: A write to address 0 loads all 32 latch bits at once with the write data.
- R10: A read of address 0 returns `pin_in` through two flops, whatever the direction or function. A change is visible after the second rising edge.
- R11: Writes to addresses 4-7 are ignored while the protection flag is closed. A write to address 14 opens the flag, a write to address 15 closes it, and the data of both writes is ignored. Reads of addresses 4-7 return the stored register, and reads of any other address except 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| per_out | input | 96 | Output values of peripherals 1..3, 32 bits each |
| per_oe | input | 96 | Output enables of peripherals 1..3, 32 bits each |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Pad output enable |
| pad_pu_en | output | 32 | Pad pull-up enable |

## Verification
A register write takes effect at the clock edge that samples the strobe. The pad outputs and the read-back of control registers are therefore checked at the next falling edge, and the data path through the mux is combinational from that point on. A change on `pin_in` reaches a data read only after two rising edges. The bench checks that the old value is still visible after one edge and that the new value appears after the second. All stimulus is driven on falling edges, so every sample lands half a cycle away from the edge that produced it.

// File: rtl/gpio_port_bank.sv
`timescale 1ns/1ps
module gpio_port_bank #(
  parameter int NPIN = 32,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [3*NPIN-1:0] per_out,
  input  logic [3*NPIN-1:0] per_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu_en
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_SET  = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam logic [AW-1:0] A_TGL  = AW'(3);
  localparam logic [AW-1:0] A_DIR  = AW'(4);
  localparam logic [AW-1:0] A_PUD  = AW'(5);
  localparam logic [AW-1:0] A_FLO  = AW'(6);
  localparam logic [AW-1:0] A_FHI  = AW'(7);
  localparam logic [AW-1:0] A_OPEN = AW'(14);
  localparam logic [AW-1:0] A_SHUT = AW'(15);

  logic [NPIN-1:0]   latch_q, dir_q, pud_q, sync1_q, sync2_q;
  logic [2*NPIN-1:0] func_q;
  logic              unlocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '0;
      dir_q      <= '0;
      pud_q      <= '0;
      func_q     <= '0;
      unlocked_q <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA: latch_q <= bus_wdata;
        A_SET:  latch_q <= latch_q | bus_wdata;
        A_CLR:  latch_q <= latch_q & ~bus_wdata;
        A_TGL:  latch_q <= latch_q ^ bus_wdata;
        A_DIR:  if (unlocked_q) dir_q <= bus_wdata;
        A_PUD:  if (unlocked_q) pud_q <= bus_wdata;
        A_FLO:  if (unlocked_q) func_q[NPIN-1:0] <= bus_wdata;
        A_FHI:  if (unlocked_q) func_q[2*NPIN-1:NPIN] <= bus_wdata;
        A_OPEN: unlocked_q <= 1'b1;
        A_SHUT: unlocked_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_PUD:   bus_rdata = pud_q;
      A_FLO:   bus_rdata = func_q[NPIN-1:0];
      A_FHI:   bus_rdata = func_q[2*NPIN-1:NPIN];
      default: bus_rdata = '0;
    endcase
  end

  assign pad_pu_en = ~pud_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] sel;
    assign sel = func_q[2*i +: 2];
    always_comb begin
      case (sel)
        2'd1:    begin pad_out[i] = per_out[i];          pad_oe[i] = per_oe[i];          end
        2'd2:    begin pad_out[i] = per_out[NPIN+i];     pad_oe[i] = per_oe[NPIN+i];     end
        2'd3:    begin pad_out[i] = per_out[2*NPIN+i];   pad_oe[i] = per_oe[2*NPIN+i];   end
        default: begin pad_out[i] = latch_q[i];          pad_oe[i] = dir_q[i];           end
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
`timescale 1ns/1ps
module gpio_port_bank_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic            bus_we,
  input logic [NPIN-1:0] latch_q,
  input logic [NPIN-1:0] dir_q,
  input logic            unlocked_q
);
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=> latch_q == ($past(latch_q) | $past(bus_wdata)));
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2)) |=> latch_q == ($past(latch_q) & ~$past(bus_wdata)));
  p_tgl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3)) |=> latch_q == ($past(latch_q) ^ $past(bus_wdata)));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> latch_q == $past(bus_wdata));
  p_locked_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_q && bus_we && bus_addr == AW'(4)) |=> $stable(dir_q));
  p_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(14)) |=> unlocked_q);
  p_shut_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(15)) |=> !unlocked_q);
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .latch_q(latch_q), .dir_q(dir_q), .unlocked_q(unlocked_q)
);

// File: tb/test_gpio_port_bank.sv
`timescale 1ns/1ps
module test_gpio_port_bank;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0;
  logic        bus_we = 1'b0;
  logic [95:0] per_out = '0, per_oe = '0;
  logic [31:0] pad_out, pad_oe, pad_pu_en;
  int errors = 0, checks = 0;
  logic [31:0] latch_m = '0, dir_m = '0, lfsr = 32'h1234_5678;
  logic [63:0] func_m = '0;

  always #2.5 clk = ~clk;

  gpio_port_bank i_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .per_out(per_out),
    .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
  );

  function automatic logic [31:0] nxt(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic chk_pads(string tag);
    logic [31:0] eo, ee;
    for (int i = 0; i < 32; i++) begin
      int f;
      f = int'(func_m[2*i +: 2]);
      if (f == 0) begin eo[i] = latch_m[i]; ee[i] = dir_m[i]; end
      else begin eo[i] = per_out[(f-1)*32+i]; ee[i] = per_oe[(f-1)*32+i]; end
    end
    #0.5;
    chk({tag, " pad_out"}, pad_out, eo);
    chk({tag, " pad_oe"}, pad_oe, ee);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd4, r); chk("R1 dir", r, '0);
    rd(4'd5, r); chk("R1 pud", r, '0);
    rd(4'd6, r); chk("R1 func lo", r, '0);
    rd(4'd7, r); chk("R1 func hi", r, '0);
    chk("R1 pu_en", pad_pu_en, '1);
    chk_pads("R1");
    // R11 locked writes ignored
    for (int a = 4; a <= 7; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), r); chk("R11 locked write", r, '0);
    end
    chk_pads("R11 locked");
    wr(4'd14, 32'h0);
    wr(4'd4, 32'hA5A5_0F0F); dir_m = 32'hA5A5_0F0F;
    rd(4'd4, r); chk("R11 unlocked dir", r, dir_m);
    rd(4'd9, r); chk("R11 unmapped read", r, '0);
    // R8 preload while input, R3 direction
    wr(4'd4, 32'h0); dir_m = '0;
    wr(4'd1, 32'h00FF_00F0); latch_m = 32'h00FF_00F0;
    chk_pads("R8 preload input");
    wr(4'd4, 32'hFFFF_FFFF); dir_m = '1;
    chk_pads("R8 R3 turned output");
    wr(4'd4, 32'h3C3C_C3C3); dir_m = 32'h3C3C_C3C3;
    chk_pads("R3 mixed dir");
    // R4 R5 R6 R9 latch operations sweep
    for (int k = 0; k < 48; k++) begin
      lfsr = nxt(lfsr);
      case (k % 4)
        0: begin wr(4'd0, lfsr); latch_m = lfsr;            chk_pads("R9 data load"); end
        1: begin wr(4'd1, lfsr); latch_m = latch_m | lfsr;  chk_pads("R4 set"); end
        2: begin wr(4'd2, lfsr); latch_m = latch_m & ~lfsr; chk_pads("R5 clear"); end
        default: begin wr(4'd3, lfsr); latch_m = latch_m ^ lfsr; chk_pads("R6 toggle"); end
      endcase
    end
    wr(4'd1, 32'h0); chk_pads("R4 zero set");
    wr(4'd2, 32'h0); chk_pads("R5 zero clear");
    wr(4'd3, 32'h0); chk_pads("R6 zero toggle");
    wr(4'd3, 32'hFFFF_FFFF); latch_m = ~latch_m; chk_pads("R6 all toggle");
    // R7 pull-up
    for (int k = 0; k < 4; k++) begin
      lfsr = nxt(lfsr);
      wr(4'd5, lfsr);
      #0.5; chk("R7 pu_en", pad_pu_en, ~lfsr);
    end
    // R2 function mux sweep
    for (int f = 0; f < 5; f++) begin
      logic [31:0] w;
      w = (f < 4) ? {16{2'(f)}} : 32'hE4E4_E4E4;
      wr(4'd6, w); wr(4'd7, (f < 4) ? w : 32'h1B1B_1B1B);
      func_m = {(f < 4) ? w : 32'h1B1B_1B1B, w};
      for (int p = 0; p < 3; p++) begin
        lfsr = nxt(lfsr); per_out = {lfsr, ~lfsr, lfsr ^ 32'h5555_AAAA};
        lfsr = nxt(lfsr); per_oe  = {~lfsr, lfsr ^ 32'h0F0F_F0F0, lfsr};
        lfsr = nxt(lfsr); wr(4'd3, lfsr); latch_m = latch_m ^ lfsr;
        chk_pads("R2 function mux");
      end
    end
    rd(4'd6, r); chk("R2 func lo readback", r, 32'hE4E4_E4E4);
    // R11 lock again
    wr(4'd15, 32'hFFFF_FFFF);
    wr(4'd6, 32'h0); wr(4'd4, 32'h0);
    rd(4'd6, r); chk("R11 relocked func", r, 32'hE4E4_E4E4);
    rd(4'd4, r); chk("R11 relocked dir", r, dir_m);
    chk_pads("R11 relocked pads");
    // R10 synchronized input read
    for (int k = 0; k < 6; k++) begin
      logic [31:0] old;
      old = pin_in;
      lfsr = nxt(lfsr); pin_in = lfsr;
      bus_addr = 4'd0;
      @(posedge clk); @(negedge clk);
      rd(4'd0, r); chk("R10 one edge old", r, old);
      @(posedge clk); @(negedge clk);
      rd(4'd0, r); chk("R10 two edges new", r, lfsr);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule